// File: doc/BRIEF.md
# PHY Initialization Wait Sequencer

This block runs the bring-up handshake of a storage-interface PHY. Software writes a 32-bit timing-adjust register. Setting the top bit starts an initialization. The block then runs a fixed series of phases and drives two strobes to the PHY: a synchronizer enable and a synchronizer reset. The length of each phase comes from four 4-bit fields in the same register.

After the programmable phases, a fixed 8-cycle tail covers the bus and interface clock allowance. The start bit reads back as 1 for the whole run and as 0 once the run is over. Software can therefore poll the register for completion. It can also watch the busy level or the one-cycle done pulse.

The phase order is as follows:

- Sync-enable is high for its duration.
- The enable-to-reset gap follows.
- Sync-reset is high for its duration.
- The usage wait follows.
- The tail comes last.

A phase whose field is zero takes no cycles. All field values are captured when the run starts.

Top module: `phy_init_seq`

## Requirements
- R1: After reset, busy, done, sync_en and sync_rst are 0 and rd_data reads 0.
- R2: A write with bit 31 set while idle starts a run. busy is 1 from the cycle after the write, and rd_data bit 31 reads 1 while busy.
- R3: busy stays high for exactly (field[3:0] + field[7:4] + field[11:8] + field[15:12] + 8) cycles. After that, rd_data bit 31 reads 0.
- R4: sync_en is high for exactly field[11:8] cycles, starting in the first busy cycle.
- R5: sync_rst follows sync_en after field[7:4] low cycles and stays high for field[3:0] cycles. sync_en and sync_rst are never high together.
- R6: After sync_rst, both strobes stay low for field[15:12] cycles plus an 8-cycle tail, and busy remains high throughout.
- R7: done is a one-cycle pulse in the first cycle in which busy is low after a run.
- R8: Field values are captured at start. Writes to the register during a run update the read-back bits [30:0] but do not change the run in progress.
- R9: During a run, a write with bit 31 set does not restart or extend the run, and a write with bit 31 clear does not abort it.
- R10: With all four fields zero, a run lasts exactly 8 cycles, and both strobes stay low.
- R11: Bits [30:0] of rd_data return the last value written to them, with or without a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data; bit 31 requests a start |
| rd_data | output | 32 | Register read value; bit 31 is the live start/busy bit |
| busy | output | 1 | High for the whole initialization run |
| done | output | 1 | One-cycle pulse when a run completes |
| sync_en | output | 1 | Synchronizer enable strobe to the PHY |
| sync_rst | output | 1 | Synchronizer reset strobe to the PHY |

## Verification
A wrong phase state or a wrong counter value shows at the strobe pins in the very cycle it occurs. A strobe edge lands one cycle early or late, or a strobe that should be low is raised. A faulty captured field or a faulty tail count may leave the strobes correct and still move the falling edge of busy and the done pulse. In that case the error appears only at the end of the run. Comparing all outputs against a cycle-accurate model on every clock catches both kinds of error at the first cycle that differs.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_EN   = 3'd1,
    PH_GAP  = 3'd2,
    PH_RST  = 3'd3,
    PH_USE  = 3'd4,
    PH_TAIL = 3'd5
  } phase_t;
endpackage

// File: rtl/phy_init_regs.sv
module phy_init_regs #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             busy,
  output logic [REG_W-1:0] rd_data,
  output logic             start_req
);
  localparam int START_BIT = REG_W - 1;

  logic [START_BIT-1:0] store_q, store_d;

  always_comb begin
    store_d = store_q;
    if (wr_en) store_d = wr_data[START_BIT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else if (wr_en) store_q <= store_d;
  end

  assign start_req = wr_en & wr_data[START_BIT] & ~busy;
  assign rd_data   = {busy, store_q};

  // R11: a write always lands in the read-back bits one cycle later
  p_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[START_BIT-1:0] == $past(wr_data[START_BIT-1:0])));
endmodule

// File: rtl/phy_init_phase_ctrl.sv
module phy_init_phase_ctrl
  import phy_init_pkg::*;
#(
  parameter int FIELD_W     = 4,
  parameter int TAIL_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_req,
  input  logic [4*FIELD_W-1:0] cfg_in,
  output logic                 busy,
  output logic                 done,
  output logic                 sync_en,
  output logic                 sync_rst
);
  localparam int CFG_W   = 4 * FIELD_W;
  localparam int RST_LSB = 0;
  localparam int GAP_LSB = FIELD_W;
  localparam int EN_LSB  = 2 * FIELD_W;
  localparam int USE_LSB = 3 * FIELD_W;
  localparam int TAIL_W  = $clog2(TAIL_CYCLES + 1);
  localparam int CNT_W   = (FIELD_W > TAIL_W) ? FIELD_W : TAIL_W;

  phase_t           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CFG_W-1:0] lat_q, lat_d;
  logic             done_q, done_d;
  logic             adv;

  function automatic logic [CNT_W-1:0] dur_of(phase_t p, logic [CFG_W-1:0] f);
    logic [CNT_W-1:0] r;
    case (p)
      PH_EN:   r = CNT_W'(f[EN_LSB  +: FIELD_W]);
      PH_GAP:  r = CNT_W'(f[GAP_LSB +: FIELD_W]);
      PH_RST:  r = CNT_W'(f[RST_LSB +: FIELD_W]);
      PH_USE:  r = CNT_W'(f[USE_LSB +: FIELD_W]);
      PH_TAIL: r = CNT_W'(TAIL_CYCLES);
      default: r = '0;
    endcase
    return r;
  endfunction

  // first phase after cur whose duration is non-zero; the tail is never empty
  function automatic phase_t next_active(phase_t cur, logic [CFG_W-1:0] f);
    phase_t r;
    logic   found;
    r     = PH_TAIL;
    found = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      if (!found && (i > int'(cur)) && (dur_of(phase_t'(3'(i)), f) != '0)) begin
        r     = phase_t'(3'(i));
        found = 1'b1;
      end
    end
    return r;
  endfunction

  assign adv = (st_q != PH_IDLE) | start_req;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    lat_d  = lat_q;
    done_d = 1'b0;
    if (st_q == PH_IDLE) begin
      if (start_req) begin
        lat_d = cfg_in;
        st_d  = next_active(PH_IDLE, cfg_in);
        cnt_d = dur_of(st_d, cfg_in) - 1'b1;
      end
    end else if (cnt_q == '0) begin
      if (st_q == PH_TAIL) begin
        st_d   = PH_IDLE;
        done_d = 1'b1;
      end else begin
        st_d  = next_active(st_q, lat_q);
        cnt_d = dur_of(st_d, lat_q) - 1'b1;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
      lat_q <= '0;
    end else if (adv) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lat_q <= lat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign busy     = (st_q != PH_IDLE);
  assign done     = done_q;
  assign sync_en  = (st_q == PH_EN);
  assign sync_rst = (st_q == PH_RST);

  // tail length monitor for R6
  logic [CNT_W:0] tail_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tail_run_q <= '0;
    else if (st_q == PH_TAIL) tail_run_q <= tail_run_q + 1'b1;
    else                      tail_run_q <= '0;
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> busy);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_en && sync_rst));
  p_tail_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PH_TAIL && tail_run_q != '0) |-> (tail_run_q == (CNT_W+1)'(TAIL_CYCLES)));
  p_done_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_fell_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_lat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(lat_q));
endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq #(
  parameter int REG_W       = 32,
  parameter int FIELD_W     = 4,
  parameter int TAIL_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             busy,
  output logic             done,
  output logic             sync_en,
  output logic             sync_rst
);
  localparam int CFG_W = 4 * FIELD_W;

  logic start_req;

  phy_init_regs #(.REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .busy      (busy),
    .rd_data   (rd_data),
    .start_req (start_req)
  );

  phy_init_phase_ctrl #(.FIELD_W(FIELD_W), .TAIL_CYCLES(TAIL_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .cfg_in    (wr_data[CFG_W-1:0]),
    .busy      (busy),
    .done      (done),
    .sync_en   (sync_en),
    .sync_rst  (sync_rst)
  );

  // R9: a write with the start bit clear never ends a run early
  p_no_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !wr_data[REG_W-1] && !done) |=> (busy || done));
endmodule

// File: tb/phy_init_seq_test.sv
`timescale 1ns/1ps
module phy_init_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        busy, done, sync_en, sync_rst;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  phy_init_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .done(done),
    .sync_en(sync_en), .sync_rst(sync_rst)
  );

  // behavioural reference: per-cycle strobe pattern queue {en,rst}
  logic [1:0]  pat_q[$];
  logic        m_busy, m_done, m_en, m_rst;
  logic [30:0] m_store;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q.delete();
      m_busy = 0; m_done = 0; m_en = 0; m_rst = 0; m_store = '0;
    end else begin
      logic prev;
      logic [1:0] e;
      prev = m_busy;
      if (wr_en && wr_data[31] && !m_busy) begin
        for (int i = 0; i < int'(wr_data[11:8]); i++) pat_q.push_back(2'b10);
        for (int i = 0; i < int'(wr_data[7:4]); i++)  pat_q.push_back(2'b00);
        for (int i = 0; i < int'(wr_data[3:0]); i++)  pat_q.push_back(2'b01);
        for (int i = 0; i < int'(wr_data[15:12]) + 8; i++) pat_q.push_back(2'b00);
      end
      if (wr_en) m_store = wr_data[30:0];
      if (pat_q.size() > 0) begin
        e = pat_q.pop_front();
        m_busy = 1; m_en = e[1]; m_rst = e[0];
      end else begin
        m_busy = 0; m_en = 0; m_rst = 0;
      end
      m_done = prev && !m_busy;
    end
  end

  task automatic chk(string tag, string name, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) %s act=%h exp=%h", tag, cur_tag, name, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk("R3",  "busy",     32'(busy),     32'(m_busy));
      chk("R7",  "done",     32'(done),     32'(m_done));
      chk("R4",  "sync_en",  32'(sync_en),  32'(m_en));
      chk("R5",  "sync_rst", 32'(sync_rst), 32'(m_rst));
      chk("R11", "rd_data",  rd_data,       {m_busy, m_store});
    end
  end

  task automatic wr(logic [31:0] v);
    wr_en = 1; wr_data = v;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  // start a run from idle and measure its busy length and strobe counts
  task automatic run_seq(logic [31:0] v, int exp_len, string tag);
    int n, ne, nr;
    cur_tag = tag;
    wr(v);
    n = 0; ne = 0; nr = 0;
    while (busy) begin
      n++; ne += int'(sync_en); nr += int'(sync_rst);
      @(negedge clk);
    end
    chk("R3", "run_len", 32'(n), 32'(exp_len));
    chk("R4", "en_cnt",  32'(ne), 32'(v[11:8]));
    chk("R5", "rst_cnt", 32'(nr), 32'(v[3:0]));
    chk("R7", "done_at_end", 32'(done), 32'd1);
    chk("R3", "start_bit_clear", 32'(rd_data[31]), 32'd0);
    @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "busy_rst", 32'(busy), 0);
    chk("R1", "done_rst", 32'(done), 0);
    chk("R1", "strobes_rst", 32'({sync_en, sync_rst}), 0);
    chk("R1", "rd_rst", rd_data, 0);
    rst_n = 1;
    @(negedge clk);

    cur_tag = "R11";
    wr(32'h2BCD_1234);
    chk("R11", "readback", rd_data, 32'h2BCD_1234);

    // R2 start, mixed fields: use 3, en 2, gap 4, rst 1
    cur_tag = "R2";
    wr(32'h8000_3241);
    chk("R2", "busy_after_write", 32'(busy), 1);
    chk("R2", "bit31_busy", 32'(rd_data[31]), 1);
    chk("R4", "en_first_cycle", 32'(sync_en), 1);
    while (busy) @(negedge clk);
    @(negedge clk);

    run_seq(32'h8000_3241, 18, "R3");
    run_seq(32'h8000_0000, 8,  "R10");
    run_seq(32'h8000_0305, 16, "R5");
    run_seq(32'h8000_FFFF, 68, "R6");

    // R8/R9: writes during a run
    cur_tag = "R8";
    wr(32'h8000_2222);
    repeat (2) @(negedge clk);
    wr(32'h0ABC_0F0F);
    chk("R8", "readback_busy", rd_data, 32'h8ABC_0F0F);
    cur_tag = "R9";
    wr(32'h8000_FFFF);
    wr(32'h0000_0000);
    chk("R9", "still_busy", 32'(busy), 1);
    begin
      int n;
      n = 5;
      while (busy) begin n++; @(negedge clk); end
      chk("R9", "len_unchanged", 32'(n), 32'd16);
    end
    @(negedge clk);

    // back-to-back start right after done
    cur_tag = "R2";
    wr(32'h8000_0010);
    while (!done) @(negedge clk);
    wr(32'h8000_1000);
    chk("R2", "restart", 32'(busy), 1);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog (%s) act=timeout exp=finish", cur_tag);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule